// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block is the transmit half of one DMA channel. After a start pulse it fetches a four-word data descriptor from memory. It streams the bytes between the descriptor's buffer start and its exclusive end pointer onto a byte-wide outbound stream, writes the descriptor back, and follows the next pointer to the following descriptor. Bytes are sent in chunks of at most `CHUNK_MAX`. A descriptor flagged as the last of the list ends the walk. In that case the engine reads the flag word of the parent context descriptor, writes it back with its disable bit set, raises its end-of-list flag and returns to idle.

Packet boundaries come from the descriptors. The final byte of a descriptor carries the stream's last marker only when that descriptor asks for end of packet. A metadata sideband gives a 16-bit tag once per packet: for the first descriptor of a walk and for every descriptor that follows one that closed a packet. A one-cycle notification pulse marks each finished descriptor that asks for an interrupt. Memory is reached through a single word-wide request/acknowledge port.

Top module: `txw_walker`

## Requirements
- R1: After reset the engine is idle: running, end-of-list, stream valid, memory request and metadata valid are all 0. A start pulse while idle makes running 1 and clears end-of-list in the next cycle. A start pulse while running is ignored and does not change the walk.
- R2: A descriptor at byte address D is read as four words at D, D+4, D+8 and D+12, holding next pointer, buffer start, flag word and end pointer. In the flag word, bit 0 is end-of-list, bit 3 is end-of-packet and bit 4 is interrupt request, and bits [31:16] are the metadata tag.
- R3: The bytes of a descriptor leave in rising address order, from the buffer start up to but not including the end pointer. The byte at address A is bits [8*(A mod 4)+7 : 8*(A mod 4)] of the word at A with its two low bits cleared.
- R4: Data moves in chunks of min(end - position, CHUNK_MAX) bytes. The visible position output is set to the buffer start when a descriptor is fetched and to the end of each chunk once that chunk has been sent.
- R5: The last marker is 1 only on the final byte of a descriptor whose end-of-packet flag is 1, and nowhere else. A descriptor whose end equals its start sends no bytes.
- R6: While valid is 1 and ready is 0, valid, data and last hold their values in the next cycle.
- R7: The metadata strobe pulses for one cycle with the tag of the first descriptor of a walk, and with the tag of every descriptor that follows one with end-of-packet set. The pulse comes before any byte of that descriptor and while stream valid is 0.
- R8: The notification output pulses for one cycle once per finished descriptor whose interrupt flag is 1, and never for other descriptors.
- R9: Each finished descriptor has its four words written back unchanged, once each, to the addresses they were read from. A walk over N descriptors makes exactly 4N+1 writes.
- R10: When the finished descriptor has end-of-list set, the flag word at context address C+4 is read and written back with bit 15 set and all other bits unchanged. End-of-list then becomes 1 and running becomes 0. Otherwise the next pointer is followed.
- R11: Once end-of-list is set and no new start arrives, the engine issues no memory request and no stream data.
- R12: A memory request that is not acknowledged stays asserted with the same address, direction and write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| first_desc_i | input | 32 | Byte address of the first data descriptor |
| ctx_desc_i | input | 32 | Byte address of the parent context descriptor |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access completes in this cycle |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Stream sink accepts |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | Final byte of a packet |
| md_valid_o | output | 1 | Metadata strobe |
| md_data_o | output | 16 | Metadata tag |
| desc_intr_o | output | 1 | Finished-descriptor notification pulse |
| running_o | output | 1 | Walk in progress |
| eol_o | output | 1 | End of list reached |
| cur_desc_o | output | 32 | Address of the current descriptor |
| cur_pos_o | output | 32 | Saved buffer position |

## Verification
A wrong chunk counter or position register shows on the stream within the same descriptor. Bytes are then skipped, repeated or taken from the wrong lane, or the last marker falls one byte off, and the position output shows a chunk end other than the computed one. A lost or stale packet-start flag shows as a missing or extra metadata strobe, or as a strobe recorded after the wrong byte count. The bench compares the strobe's byte offset as well as its tag. Errors in the write-back and context paths show only once the walk ends, as a wrong per-address write count, a wrong total number of writes or a context word without bit 15.

// File: rtl/txw_pkg.sv
package txw_pkg;

    localparam int WORD_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int BPW        = WORD_W / BYTE_W;
    localparam int LANE_W     = $clog2(BPW);
    localparam int MD_W       = 16;
    localparam int DESC_WORDS = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);

    // word slots inside a data descriptor (fetch and write-back order)
    localparam int IDX_NEXT  = 0;
    localparam int IDX_BUF   = 1;
    localparam int IDX_FLAGS = 2;
    localparam int IDX_AFTER = 3;

    // flag word bit positions
    localparam int FB_EOL   = 0;
    localparam int FB_EOP   = 3;
    localparam int FB_INTR  = 4;
    localparam int FB_MD_LO = 16;

    // context descriptor: flag word offset and its disable bit
    localparam int CTX_FLAG_OFS = 4;
    localparam int CTX_DIS_BIT  = 15;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_PLAN,
        ST_RDWORD,
        ST_SEND,
        ST_FINISH,
        ST_WBACK,
        ST_CTX_RD,
        ST_CTX_WR
    } walk_state_e;

    typedef struct packed {
        logic [MD_W-1:0] md;
        logic            eol;
        logic            out_eop;
        logic            intr;
    } dflags_t;

    function automatic dflags_t decode_flags(input logic [WORD_W-1:0] w);
        dflags_t f;
        f.md      = w[FB_MD_LO +: MD_W];
        f.eol     = w[FB_EOL];
        f.out_eop = w[FB_EOP];
        f.intr    = w[FB_INTR];
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] slot_addr(input logic [WORD_W-1:0] base,
                                                     input logic [IDX_W-1:0]  idx);
        return base + (WORD_W'(idx) << LANE_W);
    endfunction

    function automatic logic [WORD_W-1:0] word_align(input logic [WORD_W-1:0] a);
        return {a[WORD_W-1:LANE_W], {LANE_W{1'b0}}};
    endfunction

endpackage

// File: rtl/txw_chunk_plan.sv
module txw_chunk_plan
    import txw_pkg::*;
#(
    parameter int CHUNK_MAX = 2048,
    parameter int LEN_W     = 12
) (
    input  logic [WORD_W-1:0] pos_i,
    input  logic [WORD_W-1:0] after_i,
    input  logic              out_eop_i,
    output logic [LEN_W-1:0]  len_o,
    output logic              ends_pkt_o,
    output logic              empty_o
);

    logic [WORD_W-1:0] remain;
    logic              fits;

    assign remain     = after_i - pos_i;
    assign fits       = remain <= WORD_W'(CHUNK_MAX);
    assign empty_o    = (remain == '0);
    assign len_o      = fits ? remain[LEN_W-1:0] : LEN_W'(CHUNK_MAX);
    // a chunk closes a packet only if it reaches the end pointer
    assign ends_pkt_o = fits && !empty_o && out_eop_i;

endmodule

// File: rtl/txw_lane_sel.sv
module txw_lane_sel
    import txw_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [LANE_W-1:0] lane_i,
    output logic [BYTE_W-1:0] byte_o
);

    logic [BYTE_W-1:0] lanes [BPW];

    for (genvar g = 0; g < BPW; g++) begin : g_lane
        assign lanes[g] = word_i[g*BYTE_W +: BYTE_W];
    end

    assign byte_o = lanes[lane_i];

endmodule

// File: rtl/txw_walker.sv
module txw_walker
    import txw_pkg::*;
#(
    parameter int CHUNK_MAX = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] first_desc_i,
    input  logic [WORD_W-1:0] ctx_desc_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [WORD_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic [BYTE_W-1:0] tx_data_o,
    output logic              tx_last_o,
    output logic              md_valid_o,
    output logic [MD_W-1:0]   md_data_o,
    output logic              desc_intr_o,
    output logic              running_o,
    output logic              eol_o,
    output logic [WORD_W-1:0] cur_desc_o,
    output logic [WORD_W-1:0] cur_pos_o
);

    localparam int LEN_W = $clog2(CHUNK_MAX + 1);
    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(DESC_WORDS - 1);
    localparam logic [LANE_W-1:0] LANE_END = LANE_W'(BPW - 1);

    walk_state_e                         state_q;
    logic [IDX_W-1:0]                    idx_q;
    logic [DESC_WORDS-1:0][WORD_W-1:0]   dsc_q;
    logic [WORD_W-1:0]                   desc_addr_q;
    logic [WORD_W-1:0]                   ctx_addr_q;
    logic [WORD_W-1:0]                   ctx_flags_q;
    logic [WORD_W-1:0]                   pos_q;
    logic [WORD_W-1:0]                   wpos_q;
    logic [LEN_W-1:0]                    rem_q;
    logic                                pkt_end_q;
    logic [WORD_W-1:0]                   wbuf_q;
    logic                                send_md_q;
    logic                                eol_q;
    logic                                md_valid_q;
    logic [MD_W-1:0]                     md_data_q;
    logic                                intr_q;

    dflags_t           fl;
    logic [LEN_W-1:0]  plan_len;
    logic              plan_pkt_end;
    logic              plan_empty;
    logic [WORD_W-1:0] wpos_next;

    assign fl        = decode_flags(dsc_q[IDX_FLAGS]);
    assign wpos_next = wpos_q + WORD_W'(1);

    txw_chunk_plan #(
        .CHUNK_MAX (CHUNK_MAX),
        .LEN_W     (LEN_W)
    ) u_plan (
        .pos_i      (pos_q),
        .after_i    (dsc_q[IDX_AFTER]),
        .out_eop_i  (fl.out_eop),
        .len_o      (plan_len),
        .ends_pkt_o (plan_pkt_end),
        .empty_o    (plan_empty)
    );

    txw_lane_sel u_lane (
        .word_i (wbuf_q),
        .lane_i (wpos_q[LANE_W-1:0]),
        .byte_o (tx_data_o)
    );

    // memory port, driven from registered state only
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (state_q)
            ST_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = slot_addr(desc_addr_q, idx_q);
            end
            ST_RDWORD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = word_align(wpos_q);
            end
            ST_WBACK: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = slot_addr(desc_addr_q, idx_q);
                mem_wdata_o = dsc_q[idx_q];
            end
            ST_CTX_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = ctx_addr_q + WORD_W'(CTX_FLAG_OFS);
            end
            ST_CTX_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = ctx_addr_q + WORD_W'(CTX_FLAG_OFS);
                mem_wdata_o = ctx_flags_q | (WORD_W'(1) << CTX_DIS_BIT);
            end
            default: ;
        endcase
    end

    assign tx_valid_o  = (state_q == ST_SEND);
    assign tx_last_o   = tx_valid_o && pkt_end_q && (rem_q == LEN_W'(1));
    assign md_valid_o  = md_valid_q;
    assign md_data_o   = md_data_q;
    assign desc_intr_o = intr_q;
    assign running_o   = (state_q != ST_IDLE);
    assign eol_o       = eol_q;
    assign cur_desc_o  = desc_addr_q;
    assign cur_pos_o   = pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            idx_q       <= '0;
            dsc_q       <= '0;
            desc_addr_q <= '0;
            ctx_addr_q  <= '0;
            ctx_flags_q <= '0;
            pos_q       <= '0;
            wpos_q      <= '0;
            rem_q       <= '0;
            pkt_end_q   <= 1'b0;
            wbuf_q      <= '0;
            send_md_q   <= 1'b0;
            eol_q       <= 1'b0;
            md_valid_q  <= 1'b0;
            md_data_q   <= '0;
            intr_q      <= 1'b0;
        end else begin
            md_valid_q <= 1'b0;
            intr_q     <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        desc_addr_q <= first_desc_i;
                        ctx_addr_q  <= ctx_desc_i;
                        eol_q       <= 1'b0;
                        send_md_q   <= 1'b1;
                        idx_q       <= '0;
                        state_q     <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack_i) begin
                        dsc_q[idx_q] <= mem_rdata_i;
                        idx_q        <= idx_q + 1'b1;
                        if (idx_q == IDX_LAST) begin
                            pos_q   <= dsc_q[IDX_BUF];
                            state_q <= ST_PLAN;
                            if (send_md_q) begin
                                md_valid_q <= 1'b1;
                                md_data_q  <= fl.md;
                                send_md_q  <= 1'b0;
                            end
                        end
                    end
                end
                ST_PLAN: begin
                    if (plan_empty) begin
                        state_q <= ST_FINISH;
                    end else begin
                        rem_q     <= plan_len;
                        pkt_end_q <= plan_pkt_end;
                        wpos_q    <= pos_q;
                        state_q   <= ST_RDWORD;
                    end
                end
                ST_RDWORD: begin
                    if (mem_ack_i) begin
                        wbuf_q  <= mem_rdata_i;
                        state_q <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (tx_ready_i) begin
                        wpos_q <= wpos_next;
                        rem_q  <= rem_q - 1'b1;
                        if (rem_q == LEN_W'(1)) begin
                            pos_q   <= wpos_next;
                            state_q <= ST_PLAN;
                        end else if (wpos_q[LANE_W-1:0] == LANE_END) begin
                            state_q <= ST_RDWORD;
                        end
                    end
                end
                ST_FINISH: begin
                    intr_q    <= fl.intr;
                    send_md_q <= fl.out_eop;
                    idx_q     <= '0;
                    state_q   <= ST_WBACK;
                end
                ST_WBACK: begin
                    if (mem_ack_i) begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == IDX_LAST) begin
                            if (fl.eol) begin
                                state_q <= ST_CTX_RD;
                            end else begin
                                desc_addr_q <= dsc_q[IDX_NEXT];
                                state_q     <= ST_FETCH;
                            end
                        end
                    end
                end
                ST_CTX_RD: begin
                    if (mem_ack_i) begin
                        ctx_flags_q <= mem_rdata_i;
                        state_q     <= ST_CTX_WR;
                    end
                end
                ST_CTX_WR: begin
                    if (mem_ack_i) begin
                        eol_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/txw_walker_checker.sv
module txw_walker_checker
    import txw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              running_o,
    input logic              eol_o,
    input logic              tx_valid_o,
    input logic              tx_ready_i,
    input logic [BYTE_W-1:0] tx_data_o,
    input logic              tx_last_o,
    input logic              md_valid_o,
    input logic              mem_req_o,
    input logic              mem_ack_i,
    input logic              mem_we_o,
    input logic [WORD_W-1:0] mem_addr_o,
    input logic [WORD_W-1:0] mem_wdata_o
);

    p_start_clears_r1: assert property (@(posedge clk) disable iff (rst)
        start_i && !running_o |=> running_o && !eol_o);

    p_last_in_beat_r5: assert property (@(posedge clk) disable iff (rst)
        tx_last_o |-> tx_valid_o);

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));

    p_md_no_data_r7: assert property (@(posedge clk) disable iff (rst)
        md_valid_o |-> !tx_valid_o);

    p_quiet_at_eol_r11: assert property (@(posedge clk) disable iff (rst)
        eol_o |-> !running_o && !tx_valid_o && !mem_req_o);

    p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                    && $stable(mem_we_o) && $stable(mem_wdata_o));

endmodule

bind txw_walker txw_walker_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .running_o   (running_o),
    .eol_o       (eol_o),
    .tx_valid_o  (tx_valid_o),
    .tx_ready_i  (tx_ready_i),
    .tx_data_o   (tx_data_o),
    .tx_last_o   (tx_last_o),
    .md_valid_o  (md_valid_o),
    .mem_req_o   (mem_req_o),
    .mem_ack_i   (mem_ack_i),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
);

// File: tb/txw_walker_test.sv
module txw_walker_test;
    import txw_pkg::*;

    localparam int CHUNK = 8;
    localparam int MEMW  = 1024;
    localparam logic [31:0] CTX = 32'h0000_0F00;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] first_desc = '0;
    logic [31:0] ctx_desc = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_ready, tx_last;
    logic [7:0]  tx_data;
    logic        md_valid, desc_intr, running, eol;
    logic [15:0] md_data;
    logic [31:0] cur_desc, cur_pos;

    txw_walker #(.CHUNK_MAX(CHUNK)) uut (
        .clk(clk), .rst(rst), .start_i(start), .first_desc_i(first_desc),
        .ctx_desc_i(ctx_desc), .mem_req_o(mem_req), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .mem_ack_i(mem_ack), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
        .tx_data_o(tx_data), .tx_last_o(tx_last), .md_valid_o(md_valid),
        .md_data_o(md_data), .desc_intr_o(desc_intr), .running_o(running),
        .eol_o(eol), .cur_desc_o(cur_desc), .cur_pos_o(cur_pos)
    );

    int n_checks = 0;
    int n_err    = 0;

    logic [31:0] mem [MEMW];
    int          wr_cnt [MEMW];
    int          total_wr;
    logic [7:0]  got_b[$];
    bit          got_l[$];
    logic [15:0] got_md[$];
    int          got_md_at[$];
    logic [31:0] pos_log[$];
    logic [31:0] last_pos;
    int          intr_cnt, stall_bad, busy_cnt;
    int          ready_pct = 100;
    bit          stall_p = 1'b0;
    logic [7:0]  stall_d;
    bit          stall_l;

    logic [31:0] d_addr [16];
    logic [31:0] d_buf  [16];
    int          d_len  [16];
    logic [15:0] d_md   [16];
    bit          d_eop  [16];
    bit          d_intr [16];
    int          n_desc;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // sink and memory model: decisions at the falling edge
    always @(negedge clk) begin
        if (rst) begin
            mem_ack   = 1'b0;
            mem_rdata = '0;
            tx_ready  = 1'b0;
            stall_p   = 1'b0;
        end else begin
            if (stall_p && !(tx_valid && tx_data == stall_d && tx_last == stall_l))
                stall_bad++;
            tx_ready  = ($urandom_range(99) < ready_pct);
            mem_ack   = mem_req && ($urandom_range(3) != 0);
            mem_rdata = '0;
            if (mem_ack) begin
                if (mem_we) begin
                    mem[mem_addr[11:2]] = mem_wdata;
                    wr_cnt[mem_addr[11:2]]++;
                    total_wr++;
                end else begin
                    mem_rdata = mem[mem_addr[11:2]];
                end
            end
            if (tx_valid && tx_ready) begin
                got_b.push_back(tx_data);
                got_l.push_back(tx_last);
            end
            stall_p = tx_valid && !tx_ready;
            stall_d = tx_data;
            stall_l = tx_last;
            if (md_valid) begin
                got_md.push_back(md_data);
                got_md_at.push_back(got_b.size());
            end
            if (desc_intr) intr_cnt++;
            if (cur_pos !== last_pos) begin
                pos_log.push_back(cur_pos);
                last_pos = cur_pos;
            end
            if (mem_req || tx_valid) busy_cnt++;
        end
    end

    function automatic logic [7:0] byte_at(input logic [31:0] a);
        logic [31:0] w;
        w = mem[a[11:2]];
        return w[8*a[1:0] +: 8];
    endfunction

    task automatic set_desc(input int i, input logic [31:0] a, input logic [31:0] b,
                            input int len, input logic [15:0] md, input bit eop, input bit intr);
        d_addr[i] = a; d_buf[i] = b; d_len[i] = len;
        d_md[i] = md; d_eop[i] = eop; d_intr[i] = intr;
    endtask

    // R2: four words per descriptor, flag bits 0/3/4 and tag in [31:16]
    task automatic load_chain();
        for (int w = 256; w < 512; w++) mem[w] = $urandom;
        for (int i = 0; i < n_desc; i++) begin
            logic [31:0] fw;
            fw = {d_md[i], 16'h0} | {27'h0, d_intr[i], d_eop[i], 2'b00, (i == n_desc - 1)};
            if ($urandom_range(1) == 1) fw = fw | 32'h0000_0820;
            mem[d_addr[i][11:2]]     = (i == n_desc - 1) ? 32'h0000_0770 : d_addr[i + 1];
            mem[d_addr[i][11:2] + 1] = d_buf[i];
            mem[d_addr[i][11:2] + 2] = fw;
            mem[d_addr[i][11:2] + 3] = d_buf[i] + d_len[i];
        end
        mem[CTX[11:2]]     = $urandom;
        mem[CTX[11:2] + 1] = $urandom & 32'hFFFF_7FFF;
    endtask

    task automatic run_check(input string tag, input bit poke);
        logic [7:0]  eb[$];
        bit          el[$];
        logic [15:0] em[$];
        int          em_at[$];
        int          eintr;
        logic [31:0] dsnap [16][4];
        logic [31:0] ctx_orig;
        int          cyc;
        bit          ok;
        bit          poked;

        eintr = 0;
        for (int i = 0; i < n_desc; i++) begin
            if (i == 0 || d_eop[i - 1]) begin
                em.push_back(d_md[i]);
                em_at.push_back(eb.size());
            end
            for (int k = 0; k < d_len[i]; k++) begin
                eb.push_back(byte_at(d_buf[i] + k));
                el.push_back(d_eop[i] && k == d_len[i] - 1);
            end
            if (d_intr[i]) eintr++;
            for (int w = 0; w < 4; w++) dsnap[i][w] = mem[d_addr[i][11:2] + w];
        end
        ctx_orig = mem[CTX[11:2] + 1];

        got_b.delete(); got_l.delete(); got_md.delete(); got_md_at.delete(); pos_log.delete();
        intr_cnt = 0; stall_bad = 0; total_wr = 0;
        for (int w = 0; w < MEMW; w++) wr_cnt[w] = 0;
        last_pos = cur_pos;

        @(negedge clk);
        start = 1'b1; first_desc = d_addr[0]; ctx_desc = CTX;
        @(negedge clk);
        start = 1'b0;
        chk(running && !eol, "R1", {tag, " start accepted, eol cleared"}, {running, eol}, 2'b10);

        cyc = 0; poked = 1'b0;
        while (running && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (poke && !poked && got_b.size() > 0) begin
                start = 1'b1; first_desc = 32'h0000_00F0; ctx_desc = 32'h0000_0E00;
                poked = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(!running, "R10", {tag, " walk ends"}, running, 0);

        chk(got_b.size() == eb.size(), "R3", {tag, " byte count"}, got_b.size(), eb.size());
        ok = 1'b1;
        for (int k = 0; k < eb.size() && k < got_b.size(); k++) if (got_b[k] !== eb[k]) ok = 1'b0;
        chk(ok, "R3", {tag, " byte values"}, ok, 1);
        ok = (got_l.size() == el.size());
        for (int k = 0; k < el.size() && k < got_l.size(); k++) if (got_l[k] != el[k]) ok = 1'b0;
        chk(ok, "R5", {tag, " last marker positions"}, ok, 1);
        ok = (got_md.size() == em.size());
        for (int k = 0; k < em.size() && k < got_md.size(); k++)
            if (got_md[k] !== em[k] || got_md_at[k] != em_at[k]) ok = 1'b0;
        chk(ok, "R7", {tag, " metadata tags and offsets"}, got_md.size(), em.size());
        chk(intr_cnt == eintr, "R8", {tag, " notification count"}, intr_cnt, eintr);
        ok = 1'b1;
        for (int i = 0; i < n_desc; i++)
            for (int w = 0; w < 4; w++)
                if (wr_cnt[d_addr[i][11:2] + w] != 1 || mem[d_addr[i][11:2] + w] !== dsnap[i][w]) ok = 1'b0;
        chk(ok, "R9", {tag, " descriptor write-back"}, ok, 1);
        chk(total_wr == 4 * n_desc + 1, "R9", {tag, " total writes"}, total_wr, 4 * n_desc + 1);
        chk(mem[CTX[11:2] + 1] === (ctx_orig | 32'h0000_8000) && wr_cnt[CTX[11:2] + 1] == 1,
            "R10", {tag, " context disable bit"}, mem[CTX[11:2] + 1], ctx_orig | 32'h0000_8000);
        chk(eol === 1'b1, "R10", {tag, " end-of-list flag"}, eol, 1);
        chk(cur_pos == d_buf[n_desc - 1] + d_len[n_desc - 1], "R4", {tag, " final position"},
            cur_pos, d_buf[n_desc - 1] + d_len[n_desc - 1]);
        chk(stall_bad == 0, "R6", {tag, " stalled beat held"}, stall_bad, 0);

        busy_cnt = 0;
        repeat (30) @(negedge clk);
        chk(busy_cnt == 0 && eol, "R11", {tag, " quiet after end of list"}, busy_cnt, 0);
    endtask

    initial begin
        #(8 * 150000);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int w = 0; w < MEMW; w++) begin mem[w] = '0; wr_cnt[w] = 0; end
        repeat (3) @(negedge clk);
        chk(!running && !eol && !tx_valid && !mem_req && !md_valid, "R1", "reset state",
            {running, eol, tx_valid, mem_req, md_valid}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!running && !mem_req, "R1", "idle after reset", {running, mem_req}, 0);

        // directed: one descriptor split into chunks of CHUNK bytes
        ready_pct = 100;
        n_desc = 1;
        set_desc(0, 32'h40, 32'h400, 20, 16'hA5C3, 1'b1, 1'b1);
        load_chain();
        run_check("single", 1'b0);
        chk(pos_log.size() == 4 && pos_log[0] == 32'h400 && pos_log[1] == 32'h408
            && pos_log[2] == 32'h410 && pos_log[3] == 32'h414, "R4", "chunk end positions",
            pos_log.size(), 4);

        // directed: empty descriptor in the middle, packet tags chain
        ready_pct = 60;
        n_desc = 3;
        set_desc(0, 32'h80, 32'h443, 5, 16'h1111, 1'b1, 1'b0);
        set_desc(1, 32'h20, 32'h480, 0, 16'h2222, 1'b1, 1'b1);
        set_desc(2, 32'hC0, 32'h4C1, 3, 16'h3333, 1'b0, 1'b1);
        load_chain();
        run_check("empty", 1'b0);

        // random chains, one with a start pulse during the walk
        for (int r = 0; r < 6; r++) begin
            ready_pct = 30 + 14 * r;
            n_desc = $urandom_range(1, 10);
            for (int i = 0; i < n_desc; i++)
                set_desc(i, 32'(16 * ((i * 5 + 3) % 16)), 32'(32'h400 + 64 * i + $urandom_range(3)),
                         ($urandom_range(4) == 0) ? 0 : $urandom_range(1, 40),
                         16'($urandom), 1'($urandom), 1'($urandom));
            load_chain();
            run_check($sformatf("rand%0d", r), r == 2);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule